// File: doc/BRIEF.md
# UART Interrupt Source Arbiter

This block decides, every clock cycle, which of five UART interrupt causes is presented to the processor. It drives a 4-bit identification code and a single request line. It owns three pieces of state. The first is the error part of the line status. The second is the receive character-timeout counter. The third is the pending flag that records that the transmit holding register has just emptied. The surrounding UART supplies the other inputs: the receive FIFO level, the trigger select, the enables and the modem delta bits.

Each receive FIFO entry carries its own error flags. While an entry sits at the FIFO head, its flags are folded into the line status error bits. A strobe tells the FIFO to wipe those flags from the entry. As a result, software sees an error when the faulty character reaches the front of the queue, not when it arrives.

Top module: `uart_irq_ident`

## Requirements
- R1: When several causes are active, the code of the highest one is shown. The causes and their codes, from highest to lowest, are:
  - line status error: 0x6
  - receive data available: 0x4
  - character timeout: 0xC
  - transmit holding empty: 0x2
  - modem status change: 0x0
- R2: With no active cause, `iir` is 0x1 and `irq` is low. Whenever `iir` differs from 0x1, `irq` is high. After reset, `iir` is 0x1 and `lsr_err` is 0.
- R3: A line status cause is active when `ier_en[2]` is set and any bit of `lsr_err` is set. The bits of `lsr_err` are: [0] overrun, [1] parity, [2] framing, [3] break.
- R4: A receive data cause is active when all of the following hold:
  - `ier_en[0]` is set.
  - `data_ready` is high.
  - `rx_level` is at or above the trigger level. With the default depth of 16, `trig_sel` values 0, 1, 2 and 3 give trigger levels of 1, 4, 8 and 14.
- R5: A timeout cause is active when all of the following hold:
  - `ier_en[0]` is set.
  - `rx_level` is nonzero.
  - The timeout counter is at least 4 × `char_time`.
- R6: The timeout counter clears at a clock edge where `rx_push` or `rx_pop` is high. Otherwise it increments at each edge where `data_ready` is high. It holds while `data_ready` is low.
- R7: A `tx_last_move` pulse sets the holding-empty pending flag. While `ier_en[1]` is set, the pending flag is reported as code 0x2.
- R8: `thr_write` clears the pending flag, and wins over a `tx_last_move` in the same cycle. `iir_rd` clears the flag only in a cycle where `iir` shows 0x2. A `tx_last_move` in that same cycle wins over this clear.
- R9: A modem cause is active when `ier_en[3]` is set and any bit of `msr_delta` is set.
- R10: In a cycle where `rx_level` is nonzero and `head_err` is nonzero, `head_err_clr` is high, and `head_err` is ORed into `lsr_err` at the next edge. When `rx_level` is zero, `head_err` has no effect.
- R11: An `overrun_set` pulse sets `lsr_err[0]` at the next edge.
- R12: `lsr_rd` clears `lsr_err` at the next edge. Error bits that arrive in the same cycle are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ier_en | input | 4 | Cause enables: [0] receive/timeout, [1] holding empty, [2] line status, [3] modem |
| data_ready | input | 1 | Receive data ready flag |
| rx_level | input | clog2(FIFO_DEPTH+1) | Receive FIFO fill level |
| trig_sel | input | 2 | Receive trigger level select |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_pop | input | 1 | A character was read from the receive FIFO |
| head_err | input | 4 | Error flags of the FIFO head entry |
| head_err_clr | output | 1 | Wipe the error flags of the head entry |
| overrun_set | input | 1 | Receive overrun event |
| lsr_rd | input | 1 | Line status register read |
| lsr_err | output | 4 | Sticky line status error bits |
| char_time | input | CT_W | Character time in clock cycles |
| tx_last_move | input | 1 | Last transmit entry moved to the shifter |
| thr_write | input | 1 | Write to the transmit data register |
| iir_rd | input | 1 | Identification register read |
| msr_delta | input | 4 | Modem status delta bits |
| iir | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
- **Combinational results.** The code, the request and `head_err_clr` are combinational functions of the inputs and the present state. The bench changes inputs just after a falling edge and compares one time unit later, before any rising edge.
- **Registered results.** The error bits, the pending flag and the timeout counter change at the rising edge after their stimulus. These are checked at the next falling edge.
- **Timeout timing.** The timeout case counts rising edges from the edge that sampled `rx_push`. No code change is expected before 4 × `char_time` edges. The change is expected exactly at that edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   typedef enum logic [3:0] {
      IID_MODEM = 4'h0,
      IID_NONE  = 4'h1,
      IID_THRE  = 4'h2,
      IID_RDA   = 4'h4,
      IID_LINE  = 4'h6,
      IID_CTO   = 4'hC
   } iid_e;

   // enable bit positions
   localparam int EN_RX    = 0;
   localparam int EN_THRE  = 1;
   localparam int EN_LINE  = 2;
   localparam int EN_MODEM = 3;

   // receive trigger level for a select value, scaled to the FIFO depth
   function automatic int trig_level(input int sel, input int depth);
      case (sel)
         0:       return 1;
         1:       return depth / 4;
         2:       return depth / 2;
         default: return depth - 2;
      endcase
   endfunction

endpackage

// File: rtl/irq_timeout_ctr.sv
module irq_timeout_ctr #(
   parameter int CT_W    = 12,
   parameter int TO_MULT = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            data_ready,
   input  logic            restart,
   input  logic [CT_W-1:0] char_time,
   output logic            expired
);
   localparam int MW = $clog2(TO_MULT) + 1;
   localparam int TW = CT_W + MW;

   logic [TW-1:0] cnt;
   logic [TW-1:0] thresh;

   assign thresh = TW'(char_time) * TW'(TO_MULT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (data_ready && (cnt != {TW{1'b1}})) begin
         cnt <= cnt + TW'(1);
      end
   end

   assign expired = (cnt >= thresh);
endmodule

// File: rtl/irq_thre_flag.sv
module irq_thre_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic wr_clr,
   input  logic rd_clr,
   output logic pending
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
      end else if (wr_clr) begin
         pending <= 1'b0;
      end else if (set_evt) begin
         pending <= 1'b1;
      end else if (rd_clr) begin
         pending <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_lsr_merge.sv
module irq_lsr_merge #(
   parameter int ERR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             level_nz,
   input  logic [ERR_W-1:0] head_err,
   input  logic             overrun_set,
   input  logic             lsr_rd,
   output logic             head_err_clr,
   output logic [ERR_W-1:0] lsr_err
);
   logic [ERR_W-1:0] take;
   logic [ERR_W-1:0] ovr_vec;
   logic [ERR_W-1:0] base;

   assign head_err_clr = level_nz && (head_err != '0);
   assign take         = head_err_clr ? head_err : '0;
   assign ovr_vec      = {{(ERR_W-1){1'b0}}, overrun_set};
   assign base         = lsr_rd ? '0 : lsr_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lsr_err <= '0;
      end else begin
         lsr_err <= base | take | ovr_vec;
      end
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
   import uart_irq_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic [3:0]       ier_en,
   input  logic [3:0]       lsr_err,
   input  logic             data_ready,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [1:0]       trig_sel,
   input  logic             timeout,
   input  logic             thre_pend,
   input  logic [3:0]       msr_delta,
   output logic [3:0]       iir,
   output logic             irq
);
   logic [LVL_W-1:0] trig_tab [4];

   for (genvar s = 0; s < 4; s++) begin : g_trig
      assign trig_tab[s] = LVL_W'(trig_level(s, FIFO_DEPTH));
   end

   logic src_line, src_rda, src_cto, src_thre, src_ms;
   iid_e code;

   assign src_line = ier_en[EN_LINE]  && (lsr_err != 4'h0);
   assign src_rda  = ier_en[EN_RX]    && data_ready && (rx_level >= trig_tab[trig_sel]);
   assign src_cto  = ier_en[EN_RX]    && (rx_level != '0) && timeout;
   assign src_thre = ier_en[EN_THRE]  && thre_pend;
   assign src_ms   = ier_en[EN_MODEM] && (msr_delta != 4'h0);

   always_comb begin
      if (src_line)      code = IID_LINE;
      else if (src_rda)  code = IID_RDA;
      else if (src_cto)  code = IID_CTO;
      else if (src_thre) code = IID_THRE;
      else if (src_ms)   code = IID_MODEM;
      else               code = IID_NONE;
   end

   assign iir = code;
   assign irq = (code != IID_NONE);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int CT_W       = 12,
   parameter int TO_MULT    = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [3:0]                       ier_en,
   input  logic                             data_ready,
   input  logic [$clog2(FIFO_DEPTH+1)-1:0]  rx_level,
   input  logic [1:0]                       trig_sel,
   input  logic                             rx_push,
   input  logic                             rx_pop,
   input  logic [3:0]                       head_err,
   output logic                             head_err_clr,
   input  logic                             overrun_set,
   input  logic                             lsr_rd,
   output logic [3:0]                       lsr_err,
   input  logic [CT_W-1:0]                  char_time,
   input  logic                             tx_last_move,
   input  logic                             thr_write,
   input  logic                             iir_rd,
   input  logic [3:0]                       msr_delta,
   output logic [3:0]                       iir,
   output logic                             irq
);
   localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

   if (FIFO_DEPTH < 4) begin : g_bad_depth
      $error("FIFO_DEPTH must be at least 4");
   end
   if (TO_MULT < 1) begin : g_bad_mult
      $error("TO_MULT must be at least 1");
   end
   if (CT_W < 1) begin : g_bad_ctw
      $error("CT_W must be at least 1");
   end

   logic timeout_hit;
   logic thre_pend;
   logic thre_rd_clr;
   logic level_nz;

   assign level_nz    = (rx_level != '0);
   assign thre_rd_clr = iir_rd && (iir == IID_THRE);

   irq_timeout_ctr #(
      .CT_W    (CT_W),
      .TO_MULT (TO_MULT)
   ) u_to (
      .clk        (clk),
      .rst_n      (rst_n),
      .data_ready (data_ready),
      .restart    (rx_push | rx_pop),
      .char_time  (char_time),
      .expired    (timeout_hit)
   );

   irq_thre_flag u_thre (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (tx_last_move),
      .wr_clr  (thr_write),
      .rd_clr  (thre_rd_clr),
      .pending (thre_pend)
   );

   irq_lsr_merge #(
      .ERR_W (4)
   ) u_lsr (
      .clk          (clk),
      .rst_n        (rst_n),
      .level_nz     (level_nz),
      .head_err     (head_err),
      .overrun_set  (overrun_set),
      .lsr_rd       (lsr_rd),
      .head_err_clr (head_err_clr),
      .lsr_err      (lsr_err)
   );

   irq_prio_enc #(
      .FIFO_DEPTH (FIFO_DEPTH),
      .LVL_W      (LVL_W)
   ) u_enc (
      .ier_en     (ier_en),
      .lsr_err    (lsr_err),
      .data_ready (data_ready),
      .rx_level   (rx_level),
      .trig_sel   (trig_sel),
      .timeout    (timeout_hit),
      .thre_pend  (thre_pend),
      .msr_delta  (msr_delta),
      .iir        (iir),
      .irq        (irq)
   );
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
   parameter int FIFO_DEPTH = 16
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [3:0]                      ier_en,
   input logic [$clog2(FIFO_DEPTH+1)-1:0] rx_level,
   input logic [3:0]                      head_err,
   input logic                            head_err_clr,
   input logic                            overrun_set,
   input logic                            lsr_rd,
   input logic [3:0]                      lsr_err,
   input logic                            thr_write,
   input logic [3:0]                      msr_delta,
   input logic [3:0]                      iir,
   input logic                            irq
);
   assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_en == 4'h0) |-> (iir == 4'h1 && !irq));

   // R1: line status sits above every other cause
   assert_line_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_en[2] && (lsr_err != 4'h0)) |-> (iir == 4'h6));

   assert_modem_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_en == 4'b1000 && msr_delta != 4'h0) |-> (iir == 4'h0 && irq));

   assert_merge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      head_err_clr |=> ((lsr_err & $past(head_err)) == $past(head_err)));

   assert_no_merge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0) |-> !head_err_clr);

   assert_ovr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_set |=> lsr_err[0]);

   assert_wr_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      thr_write |=> (iir != 4'h2));

   assert_rd_clr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !overrun_set && !head_err_clr) |=> (lsr_err == 4'h0));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(
   .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ier_en       (ier_en),
   .rx_level     (rx_level),
   .head_err     (head_err),
   .head_err_clr (head_err_clr),
   .overrun_set  (overrun_set),
   .lsr_rd       (lsr_rd),
   .lsr_err      (lsr_err),
   .thr_write    (thr_write),
   .msr_delta    (msr_delta),
   .iir          (iir),
   .irq          (irq)
);

// File: tb/uart_irq_ident_tb.sv
`timescale 1ns/1ps
module uart_irq_ident_tb;
   localparam int DEPTH = 16;
   localparam int CT_W  = 12;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [3:0]      ier_en;
   logic            data_ready;
   logic [4:0]      rx_level;
   logic [1:0]      trig_sel;
   logic            rx_push, rx_pop;
   logic [3:0]      head_err;
   logic            head_err_clr;
   logic            overrun_set, lsr_rd;
   logic [3:0]      lsr_err;
   logic [CT_W-1:0] char_time;
   logic            tx_last_move, thr_write, iir_rd;
   logic [3:0]      msr_delta;
   logic [3:0]      iir;
   logic            irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   uart_irq_ident #(.FIFO_DEPTH(DEPTH), .CT_W(CT_W), .TO_MULT(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .ier_en(ier_en), .data_ready(data_ready),
      .rx_level(rx_level), .trig_sel(trig_sel), .rx_push(rx_push), .rx_pop(rx_pop),
      .head_err(head_err), .head_err_clr(head_err_clr), .overrun_set(overrun_set),
      .lsr_rd(lsr_rd), .lsr_err(lsr_err), .char_time(char_time),
      .tx_last_move(tx_last_move), .thr_write(thr_write), .iir_rd(iir_rd),
      .msr_delta(msr_delta), .iir(iir), .irq(irq));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic int trig_of(input int sel);
      if (sel == 0) return 1;
      if (sel == 1) return DEPTH / 4;
      if (sel == 2) return DEPTH / 2;
      return DEPTH - 2;
   endfunction

   function automatic int exp_code(input int en, input bit line, input bit rda,
                                   input bit cto, input bit thre, input bit ms);
      if (en[2] && line) return 6;
      if (en[0] && rda)  return 4;
      if (en[0] && cto)  return 12;
      if (en[1] && thre) return 2;
      if (en[3] && ms)   return 0;
      return 1;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; ier_en = 0; data_ready = 0; rx_level = 0; trig_sel = 0;
      rx_push = 0; rx_pop = 0; head_err = 0; overrun_set = 0; lsr_rd = 0;
      char_time = 0; tx_last_move = 0; thr_write = 0; iir_rd = 0; msr_delta = 0;
      repeat (3) @(negedge clk);
      #1;
      chk("R2 reset iir", iir, 1);
      chk("R2 reset irq", irq, 0);
      chk("R2 reset lsr", lsr_err, 0);
      @(negedge clk); rst_n = 1; ier_en = 4'hF;
      #1 chk("R2 idle all enabled", iir, 1);

      // R4 sweep of trigger levels
      ier_en = 4'b0001; char_time = 4095;
      @(negedge clk); rx_pop = 1;
      @(negedge clk); rx_pop = 0;
      for (int d = 0; d < 2; d++)
         for (int s = 0; s < 4; s++)
            for (int l = 0; l <= DEPTH; l++) begin
               @(negedge clk);
               data_ready = d[0]; trig_sel = s[1:0]; rx_level = l[4:0];
               #1 chk("R4 data available", iir, (d == 1 && l >= trig_of(s)) ? 4 : 1);
            end

      // R5 / R6 character timeout
      char_time = 3; trig_sel = 3; rx_level = 2; data_ready = 1;
      @(negedge clk); rx_push = 1;
      @(negedge clk); rx_push = 0;
      #1 chk("R6 restart on push", iir, 1);
      for (int k = 1; k <= 12; k++) begin
         @(negedge clk);
         #1 chk("R5 timeout window", iir, (k >= 12) ? 12 : 1);
      end
      @(negedge clk); rx_level = 0;
      #1 chk("R5 empty fifo", iir, 1);
      @(negedge clk); rx_level = 2;
      #1 chk("R5 timeout again", iir, 12);
      @(negedge clk); rx_pop = 1;
      @(negedge clk); rx_pop = 0; data_ready = 0;
      #1 chk("R6 restart on pop", iir, 1);
      repeat (20) @(negedge clk);
      #1 chk("R6 hold without data_ready", iir, 1);
      @(negedge clk); data_ready = 1;
      repeat (11) @(negedge clk);
      #1 chk("R6 count resumes", iir, 1);
      @(negedge clk);
      #1 chk("R6 count reaches limit", iir, 12);
      @(negedge clk); rx_pop = 1; data_ready = 0; rx_level = 0;
      @(negedge clk); rx_pop = 0;

      // R7 / R8 holding empty
      ier_en = 4'b0010;
      @(negedge clk); tx_last_move = 1;
      @(negedge clk); tx_last_move = 0;
      #1 chk("R7 set iir", iir, 2);
      chk("R7 set irq", irq, 1);
      @(negedge clk); iir_rd = 1;
      @(negedge clk); iir_rd = 0;
      #1 chk("R8 iir read clears", iir, 1);
      @(negedge clk); tx_last_move = 1;
      @(negedge clk); tx_last_move = 0; thr_write = 1;
      @(negedge clk); thr_write = 0;
      #1 chk("R8 write clears", iir, 1);
      @(negedge clk); tx_last_move = 1; thr_write = 1;
      @(negedge clk); tx_last_move = 0; thr_write = 0;
      #1 chk("R8 write wins", iir, 1);
      @(negedge clk); tx_last_move = 1;
      @(negedge clk); tx_last_move = 0; ier_en = 0; iir_rd = 1;
      @(negedge clk); iir_rd = 0; ier_en = 4'b0010;
      #1 chk("R8 read without report", iir, 2);
      @(negedge clk); iir_rd = 1; tx_last_move = 1;
      @(negedge clk); iir_rd = 0; tx_last_move = 0;
      #1 chk("R8 set wins over read", iir, 2);
      @(negedge clk); thr_write = 1;
      @(negedge clk); thr_write = 0;

      // R9 modem
      ier_en = 4'b1000;
      for (int b = 0; b < 4; b++) begin
         @(negedge clk); msr_delta = 4'(1 << b);
         #1 chk("R9 modem delta", iir, 0);
         chk("R9 modem irq", irq, 1);
      end
      @(negedge clk); msr_delta = 0;
      #1 chk("R9 no delta", iir, 1);
      @(negedge clk); ier_en = 0; msr_delta = 4'hF;
      #1 chk("R9 disabled", iir, 1);
      @(negedge clk); msr_delta = 0;

      // R3 / R11 / R12 line status
      ier_en = 4'b0100;
      @(negedge clk); overrun_set = 1;
      @(negedge clk); overrun_set = 0;
      #1 chk("R11 overrun bit", lsr_err, 1);
      chk("R3 line code", iir, 6);
      @(negedge clk); lsr_rd = 1;
      @(negedge clk); lsr_rd = 0;
      #1 chk("R12 read clears", lsr_err, 0);
      chk("R3 line gone", iir, 1);
      @(negedge clk); lsr_rd = 1; overrun_set = 1;
      @(negedge clk); lsr_rd = 0; overrun_set = 0;
      #1 chk("R12 set during read", lsr_err, 1);
      @(negedge clk); lsr_rd = 1;
      @(negedge clk); lsr_rd = 0;

      // R10 head error merge, every flag combination
      for (int v = 1; v < 16; v++) begin
         @(negedge clk); rx_level = 1; head_err = 4'(v);
         #1 chk("R10 clear strobe", head_err_clr, 1);
         @(negedge clk); head_err = 0;
         #1 chk("R10 merged bits", lsr_err, v);
         chk("R3 line from merge", iir, 6);
         @(negedge clk); lsr_rd = 1;
         @(negedge clk); lsr_rd = 0;
         #1 chk("R12 cleared", lsr_err, 0);
      end
      @(negedge clk); rx_level = 0; head_err = 4'h5;
      #1 chk("R10 empty no strobe", head_err_clr, 0);
      @(negedge clk); head_err = 0;
      #1 chk("R10 empty no merge", lsr_err, 0);

      // R1 priority sweep with every cause pending
      char_time = 0; data_ready = 1; rx_level = 2;
      @(negedge clk); overrun_set = 1; tx_last_move = 1;
      @(negedge clk); overrun_set = 0; tx_last_move = 0;
      for (int e = 0; e < 16; e++)
         for (int r = 0; r < 2; r++)
            for (int m = 0; m < 2; m++) begin
               @(negedge clk);
               ier_en = 4'(e); trig_sel = (r == 1) ? 2'd0 : 2'd3; msr_delta = (m == 1) ? 4'h2 : 4'h0;
               #1;
               chk("R1 priority", iir, exp_code(e, 1'b1, r == 1, 1'b1, 1'b1, m == 1));
               chk("R2 irq follows code", irq, (exp_code(e, 1'b1, r == 1, 1'b1, 1'b1, m == 1) != 1) ? 1 : 0);
            end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule